// File: doc/BRIEF.md
# Modulo-26 Five-Bit Adder

This block adds two 5-bit operands that each hold a value from 0 to 25, such as letter positions in a 26-symbol alphabet. It returns their sum wrapped modulo 26 as a 5-bit value. The reduction is split into two parts. The lowest result bit comes straight from the operands' lowest bits. The upper four bits come from a small binary sum of the operands' upper halves, followed by a modulo-13 correction.

The correction adds three, modulo 16, whenever a compact threshold term shows that the intermediate sum is 13 or more. This replaces a general compare-and-subtract stage. A parameter chooses between a registered output, which holds the sum and a valid flag for one clock and is the default, and a purely combinational path.

Operands of 26 or more are outside the contract, and the result for them is undefined. The block does no subtraction and supports no other modulus.

Top module: `mod26_adder`

## Requirements
- R1: For operands both below 26, the result presented with `outValid` equals (opA + opB) mod 26 for the operands accepted one cycle earlier.
- R2: Result bit 0 equals the XOR of bit 0 of the two accepted operands.
- R3: Whenever both accepted operands are below 26, the presented result is below 26.
- R4: `outValid` is high in exactly the cycle after a cycle in which `inValid` was high while reset was low.
- R5: A synchronous active-high `rst` drives `outValid` low and `sum` to 0 at the next rising edge.
- R6: While `inValid` is low, `sum` keeps its last value whatever the operand inputs carry.
- R7: The wrap boundaries give 25+25=24, 13+13=0, 12+0=12 and 1+25=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands on opA/opB are to be added |
| opA | input | 5 | First operand, 0 to 25 |
| opB | input | 5 | Second operand, 0 to 25 |
| outValid | output | 1 | `sum` holds a fresh result |
| sum | output | 5 | Registered (opA + opB) mod 26 |

## Verification
A faulty threshold term or correction constant shows at the port one cycle after the operands that expose it. For example, an intermediate of exactly 13 that is left uncorrected would produce a result of 26 or more. A swapped carry would yield a value that is off by two. All 676 legal pairs are driven back to back, so any such fault in the reduction is seen within about 700 cycles. A wrong load or valid strobe shows in the very next cycle, either as a changed `sum` during idle cycles or as a misplaced `outValid`.

// File: rtl/mod26_pkg.sv
package mod26_pkg;
  localparam int OPW     = 5;
  localparam int HIW     = OPW - 1;
  localparam int MODULUS = 26;

  typedef struct packed {
    logic load;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/mod26_datapath.sv
module mod26_datapath
  import mod26_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  strobe_t        strobes,
  input  logic [OPW-1:0] opA,
  input  logic [OPW-1:0] opB,
  output logic [OPW-1:0] sumOut
);
  logic           lowBit;
  logic           lowCarry;
  logic [HIW:0]   midSum;
  logic           overThirteen;
  logic [HIW-1:0] fixedHigh;
  logic [OPW-1:0] rawSum;

  // low bit passes through as a parity; its carry feeds the upper add
  assign lowBit   = opA[0] ^ opB[0];
  assign lowCarry = opA[0] & opB[0];

  // upper halves plus carry, kept to 5 bits (always below 26)
  assign midSum = {1'b0, opA[OPW-1:1]} + {1'b0, opB[OPW-1:1]}
                + {{HIW{1'b0}}, lowCarry};

  // set exactly when midSum >= 13
  assign overThirteen = midSum[4] | (midSum[3] & midSum[2] & (midSum[1] | midSum[0]));

  // add 3 modulo 16 when over threshold; carry out dropped
  assign fixedHigh = midSum[HIW-1:0] + {2'b00, overThirteen, overThirteen};

  assign rawSum = {fixedHigh, lowBit};

  generate
    if (REG_OUT) begin : g_reg
      logic [OPW-1:0] sumQ;
      always_ff @(posedge clk) begin
        if (strobes.clear)     sumQ <= '0;
        else if (strobes.load) sumQ <= rawSum;
      end
      assign sumOut = sumQ;
    end else begin : g_comb
      assign sumOut = rawSum;
    end
  endgenerate
endmodule

// File: rtl/mod26_control.sv
module mod26_control
  import mod26_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t strobes,
  output logic    outValid
);
  assign strobes.clear = rst;
  assign strobes.load  = inValid & ~rst;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/mod26_adder.sv
module mod26_adder
  import mod26_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [OPW-1:0] opA,
  input  logic [OPW-1:0] opB,
  output logic           outValid,
  output logic [OPW-1:0] sum
);
  strobe_t strobes;

  mod26_control #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  mod26_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .sumOut  (sum)
  );
endmodule

// File: rtl/mod26_adder_chk.sv
module mod26_adder_chk
  import mod26_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           inValid,
  input logic [OPW-1:0] opA,
  input logic [OPW-1:0] opB,
  input logic           outValid,
  input logic [OPW-1:0] sum
);
  function automatic logic [OPW-1:0] refMod(logic [OPW-1:0] x, logic [OPW-1:0] y);
    logic [OPW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= MODULUS[OPW:0]) s = s - MODULUS[OPW:0];
    return s[OPW-1:0];
  endfunction

  generate
    if (REG_OUT) begin : g_reg
      // R1
      mod_value_chk: assert property (@(posedge clk) disable iff (rst)
        (outValid && $past(opA) < 5'd26 && $past(opB) < 5'd26)
        |-> sum == refMod($past(opA), $past(opB)));
      // R2
      low_parity_chk: assert property (@(posedge clk) disable iff (rst)
        outValid |-> sum[0] == ($past(opA[0]) ^ $past(opB[0])));
      // R3
      no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (outValid && $past(opA) < 5'd26 && $past(opB) < 5'd26) |-> sum < 5'd26);
      // R4
      valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> outValid == $past(inValid));
      // R5
      reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!outValid && sum == '0));
      // R6
      idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(inValid) && !$past(rst)) |-> $stable(sum));
    end
  endgenerate
endmodule

bind mod26_adder mod26_adder_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .sum      (sum)
);

// File: tb/test_mod26_adder.sv
module test_mod26_adder;
  logic       clk = 1'b0;
  logic       rst;
  logic       inValid;
  logic [4:0] opA, opB;
  logic       outValid;
  logic [4:0] sum;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  // reference model state
  bit    armed     = 0;
  bit    expValid  = 0;
  int    expSum    = 0;
  int    lastA     = 0;
  int    lastB     = 0;
  string curTag    = "R1";

  always #10 clk = ~clk;  // 50 MHz

  mod26_adder i_mod26_adder (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .sum      (sum)
  );

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    if (!armed) return;
    check("R4 outValid", int'(outValid), int'(expValid));
    check((expValid ? curTag : "R6 hold"), int'(sum), expSum);
    if (expValid) begin
      check("R2 lsb", int'(sum[0]), (lastA % 2) ^ (lastB % 2));
      check("R3 range", int'(sum < 5'd26), 1);
    end
  endtask

  task automatic doCycle(bit r, bit v, int a, int b, string tag);
    @(negedge clk);
    checkOutputs();
    rst = r; inValid = v; opA = a[4:0]; opB = b[4:0];
    curTag = tag;
    armed  = 1;
    if (r) begin
      expValid = 0; expSum = 0; curTag = "R5 reset";
    end else if (v) begin
      expValid = 1; expSum = (a + b) % 26; lastA = a; lastB = b;
    end else begin
      expValid = 0;
    end
  endtask

  initial begin
    int idleCount = 0;
    rst = 1'b1; inValid = 1'b0; opA = '0; opB = '0;
    repeat (3) doCycle(1, 0, 0, 0, "R5");
    doCycle(0, 0, 0, 0, "R5");
    // R7 boundary wraps
    doCycle(0, 1, 25, 25, "R7 25+25");
    doCycle(0, 1, 13, 13, "R7 13+13");
    doCycle(0, 1, 12, 0,  "R7 12+0");
    doCycle(0, 1, 1, 25,  "R7 1+25");
    // R1 exhaustive sweep with idle cycles carrying junk operands (R6)
    for (int a = 0; a < 26; a++) begin
      for (int b = 0; b < 26; b++) begin
        doCycle(0, 1, a, b, "R1 sum");
        if (((a * 26 + b) % 7) == 3) begin
          doCycle(0, 0, 31 - (idleCount % 5), idleCount % 32, "R6");
          idleCount++;
        end
      end
    end
    // R5 mid-stream reset, then recovery
    doCycle(0, 1, 20, 19, "R1 sum");
    doCycle(1, 1, 7, 8, "R5");
    doCycle(0, 0, 9, 9, "R6");
    doCycle(0, 1, 24, 3, "R1 sum");
    doCycle(0, 0, 0, 0, "R6");
    doCycle(0, 0, 0, 0, "R6");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule